// File: doc/BRIEF.md
# Byte-Serial MOV Instruction Decoder

This block takes a stream of instruction bytes, one byte per accepted handshake, and decodes two forms of the MOV instruction. The first is the register/memory form, which moves between a register and a register-or-memory operand. The second is the immediate-to-register form. For each instruction the block produces one record. The record carries the operand direction, the operand width, the mode, register and register/memory fields, any displacement or immediate value, and the number of bytes the instruction used.

The number of bytes in an instruction is not fixed. It depends on the mode field, on the direct-address case, and on the width bit. A sequencer therefore tracks which byte it expects next. Any first byte that is neither MOV form produces a one-byte record with the illegal flag set. The byte after it is then treated as the first byte of a new instruction.

Both edges of the block use valid/ready handshakes. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. A record moves on an edge where `out_valid` and `out_ready` are both high. The block holds a single record. While that record waits with `out_ready` low, `in_ready` is low, so no input byte is taken and nothing is lost. When the record leaves in the same cycle, a new byte may be accepted in that cycle.

Top module: `mov_byte_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the first byte accepted is decoded as an opcode byte.
- R2: A first byte of the form 100010dw selects the register/memory form (`out_imm_form`=0). `out_dir` takes bit 1 and `out_wide` takes bit 0 of that byte.
- R3: In the register/memory form, the second byte gives `out_mod` from bits 7:6, `out_reg` from bits 5:3, and `out_rm` from bits 2:0.
- R4: The displacement size depends on the mode field. Mode 11, and mode 00 with r/m other than 110, have no displacement, and the length is 2. Mode 01 adds one displacement byte, placed in `out_disp[7:0]` with the upper byte zero, and the length is 3. Mode 10 adds two displacement bytes, and the length is 4.
- R5: Mode 00 with r/m 110 is followed by a 16-bit direct address, returned in `out_disp`, and the length is 4.
- R6: Multi-byte displacements and immediate values arrive low byte first. The first of the two bytes lands in bits 7:0 and the second in bits 15:8.
- R7: A first byte of the form 1011wrrr selects the immediate form. In its record, `out_imm_form` is 1, `out_dir` is 1, `out_wide` is w, and `out_reg` is rrr. Mode and r/m are zero. One data byte follows when w=0, giving length 2 with the upper byte of `out_imm` zero. Two data bytes follow when w=1, giving length 3.
- R8: Any other first byte yields a record with `out_illegal`=1, length 1, and all other fields zero. The next byte is decoded as an opcode.
- R9: While `out_valid` is 1 and `out_ready` is 0, the record stays valid and unchanged on the next cycle, and `in_ready` is 0.
- R10: The record becomes valid on the clock edge that accepts the last byte of its instruction. Exactly one record is produced per instruction, in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_illegal | output | 1 | First byte was not a supported MOV |
| out_imm_form | output | 1 | 1 for immediate-to-register, 0 for register/memory form |
| out_dir | output | 1 | 1 when the reg field is the destination |
| out_wide | output | 1 | 1 for 16-bit operands |
| out_mod | output | 2 | Mode field |
| out_reg | output | 3 | Register field |
| out_rm | output | 3 | Register/memory field |
| out_disp | output | 16 | Displacement or direct address |
| out_imm | output | 16 | Immediate data |
| out_len | output | 3 | Instruction length in bytes |

## Verification
The bench starts with directed byte streams:
- one instruction for each mode value;
- the direct-address case next to a mode 00 operand with no displacement, which shows whether the r/m 110 exception is detected;
- narrow and wide immediates, which show whether the width bit sets the data byte count;
- an illegal byte directly followed by a valid instruction, which shows that decoding starts again cleanly.

It then runs a long seeded random mix of all three kinds of first byte. Random gaps on `in_valid` and random `out_ready` stalls exercise the hold rule and confirm that no byte is dropped or duplicated under back-pressure.

// File: rtl/mov_dec_pkg.sv
package mov_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int LEN_W  = 3;

  localparam logic [5:0] RM_OPC_TOP  = 6'b100010;
  localparam logic [3:0] IMM_OPC_TOP = 4'b1011;
  localparam logic [1:0] MOD_NODISP  = 2'b00;
  localparam logic [1:0] MOD_DISP8   = 2'b01;
  localparam logic [1:0] MOD_DISP16  = 2'b10;
  localparam logic [2:0] RM_DIRECT   = 3'b110;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_MODRM,
    ST_DISP_LO,
    ST_DISP_HI,
    ST_IMM_LO,
    ST_IMM_HI
  } seq_state_e;

  typedef struct packed {
    logic              illegal;
    logic              imm_form;
    logic              dir;
    logic              wide;
    logic [1:0]        mod;
    logic [2:0]        reg_f;
    logic [2:0]        rm;
    logic [WORD_W-1:0] disp;
    logic [WORD_W-1:0] imm;
    logic [LEN_W-1:0]  len;
  } mov_rec_t;

  // Number of displacement bytes that follow the mode byte
  function automatic logic [1:0] disp_count(input logic [1:0] mod, input logic [2:0] rm);
    if (mod == MOD_DISP8)                              return 2'd1;
    else if (mod == MOD_DISP16)                        return 2'd2;
    else if (mod == MOD_NODISP && rm == RM_DIRECT)     return 2'd2;
    else                                               return 2'd0;
  endfunction
endpackage

// File: rtl/mov_opc_class.sv
module mov_opc_class
  import mov_dec_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic [BW-1:0] opc,
  output logic          is_rm,
  output logic          is_imm,
  output logic          is_bad
);
  always_comb begin
    is_rm  = (opc[BW-1 -: 6] == RM_OPC_TOP);
    is_imm = (opc[BW-1 -: 4] == IMM_OPC_TOP);
    is_bad = !(is_rm || is_imm);
  end

  always_comb begin
    assert_class_onehot_R8: assert ($countones({is_rm, is_imm, is_bad}) == 1);
  end
endmodule

// File: rtl/mov_dec_seq.sv
module mov_dec_seq
  import mov_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              done,
  output mov_rec_t          rec_now
);
  localparam int LO_HI = BYTE_W - 1;

  seq_state_e state, nxt;
  mov_rec_t   acc;
  logic       is_rm, is_imm, is_bad;
  logic [LEN_W-1:0] base_len;

  mov_opc_class #(.BW(BYTE_W)) class_i (
    .opc    (byte_in),
    .is_rm  (is_rm),
    .is_imm (is_imm),
    .is_bad (is_bad)
  );

  always_comb begin
    rec_now  = (state == ST_OPC) ? '0 : acc;
    base_len = (state == ST_OPC) ? '0 : acc.len;
    rec_now.len = base_len + LEN_W'(1);
    nxt  = state;
    done = 1'b0;
    unique case (state)
      ST_OPC: begin
        if (is_rm) begin
          rec_now.dir  = byte_in[1];
          rec_now.wide = byte_in[0];
          nxt = ST_MODRM;
        end else if (is_imm) begin
          rec_now.imm_form = 1'b1;
          rec_now.dir      = 1'b1;
          rec_now.wide     = byte_in[3];
          rec_now.reg_f    = byte_in[2:0];
          nxt = ST_IMM_LO;
        end else begin
          rec_now.illegal = is_bad;
          done = 1'b1;
        end
      end
      ST_MODRM: begin
        rec_now.mod   = byte_in[7:6];
        rec_now.reg_f = byte_in[5:3];
        rec_now.rm    = byte_in[2:0];
        if (disp_count(byte_in[7:6], byte_in[2:0]) == 2'd0) done = 1'b1;
        else nxt = ST_DISP_LO;
      end
      ST_DISP_LO: begin
        rec_now.disp[LO_HI:0] = byte_in;
        if (disp_count(acc.mod, acc.rm) == 2'd1) done = 1'b1;
        else nxt = ST_DISP_HI;
      end
      ST_DISP_HI: begin
        rec_now.disp[WORD_W-1:BYTE_W] = byte_in;
        done = 1'b1;
      end
      ST_IMM_LO: begin
        rec_now.imm[LO_HI:0] = byte_in;
        if (!acc.wide) done = 1'b1;
        else nxt = ST_IMM_HI;
      end
      ST_IMM_HI: begin
        rec_now.imm[WORD_W-1:BYTE_W] = byte_in;
        done = 1'b1;
      end
      default: begin
        done = 1'b0;
        nxt  = ST_OPC;
      end
    endcase
    if (done) nxt = ST_OPC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_OPC;
      acc   <= '0;
    end else if (take) begin
      state <= nxt;
      acc   <= rec_now;
    end
  end

  assert_hi_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (state == ST_DISP_HI || state == ST_IMM_HI)) |=> state == ST_OPC);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(state));
endmodule

// File: rtl/mov_out_stage.sv
module mov_out_stage
  import mov_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  mov_rec_t rec_in,
  input  logic     out_ready,
  output logic     out_valid,
  output mov_rec_t rec_out,
  output logic     free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rec_out   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_out   <= rec_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_load_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rec_out)));
endmodule

// File: rtl/mov_byte_decoder.sv
module mov_byte_decoder
  import mov_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_illegal,
  output logic              out_imm_form,
  output logic              out_dir,
  output logic              out_wide,
  output logic [1:0]        out_mod,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_rm,
  output logic [WORD_W-1:0] out_disp,
  output logic [WORD_W-1:0] out_imm,
  output logic [LEN_W-1:0]  out_len
);
  logic     take, done, free;
  mov_rec_t rec_now, rec_q;

  assign take     = in_valid && in_ready;
  assign in_ready = free;

  mov_dec_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (in_byte),
    .done    (done),
    .rec_now (rec_now)
  );

  mov_out_stage out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take && done),
    .rec_in    (rec_now),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_out   (rec_q),
    .free      (free)
  );

  assign out_illegal  = rec_q.illegal;
  assign out_imm_form = rec_q.imm_form;
  assign out_dir      = rec_q.dir;
  assign out_wide     = rec_q.wide;
  assign out_mod      = rec_q.mod;
  assign out_reg      = rec_q.reg_f;
  assign out_rm       = rec_q.rm;
  assign out_disp     = rec_q.disp;
  assign out_imm      = rec_q.imm;
  assign out_len      = rec_q.len;

  assert_illegal_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == 3'd1 && !out_imm_form));
  assert_imm_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imm_form) |-> (out_len == 3'd2 + {2'b0, out_wide} && out_dir));
  assert_rm_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && !out_imm_form) |-> (out_len >= 3'd2 && out_len <= 3'd4));
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/mov_byte_decoder_tb_top.sv
module mov_byte_decoder_tb_top;
  import mov_dec_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic out_valid;
  logic out_ready = 1'b0;
  logic out_illegal, out_imm_form, out_dir, out_wide;
  logic [1:0] out_mod;
  logic [2:0] out_reg, out_rm;
  logic [15:0] out_disp, out_imm;
  logic [2:0] out_len;

  always #4 clk = ~clk;

  mov_byte_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_illegal(out_illegal), .out_imm_form(out_imm_form), .out_dir(out_dir),
    .out_wide(out_wide), .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm),
    .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
  );

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] q_bytes[$];
  bit         q_last[$];
  mov_rec_t   q_exp[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] b, input bit last);
    q_bytes.push_back(b);
    q_last.push_back(last);
  endtask

  // Register/memory form per R2..R6
  task automatic add_rm(input bit d, input bit w, input logic [1:0] md,
                        input logic [2:0] rg, input logic [2:0] rmv, input logic [15:0] dv);
    mov_rec_t e;
    int n;
    n = (md == 2'b01) ? 1 : ((md == 2'b10) || (md == 2'b00 && rmv == 3'b110)) ? 2 : 0;
    e = '0;
    e.dir = d; e.wide = w; e.mod = md; e.reg_f = rg; e.rm = rmv;
    e.disp = (n == 1) ? {8'h00, dv[7:0]} : (n == 2) ? dv : 16'h0;
    e.len = 3'(2 + n);
    push_b({6'b100010, d, w}, 1'b0);
    push_b({md, rg, rmv}, n == 0);
    if (n >= 1) push_b(dv[7:0], n == 1);
    if (n == 2) push_b(dv[15:8], 1'b1);
    q_exp.push_back(e);
  endtask

  // Immediate form per R7
  task automatic add_imm(input bit w, input logic [2:0] rg, input logic [15:0] dv);
    mov_rec_t e;
    e = '0;
    e.imm_form = 1'b1; e.dir = 1'b1; e.wide = w; e.reg_f = rg;
    e.imm = w ? dv : {8'h00, dv[7:0]};
    e.len = w ? 3'd3 : 3'd2;
    push_b({4'b1011, w, rg}, 1'b0);
    push_b(dv[7:0], !w);
    if (w) push_b(dv[15:8], 1'b1);
    q_exp.push_back(e);
  endtask

  // Illegal opcode per R8
  task automatic add_bad(input logic [7:0] b);
    mov_rec_t e;
    e = '0;
    e.illegal = 1'b1; e.len = 3'd1;
    push_b(b, 1'b1);
    q_exp.push_back(e);
  endtask

  task automatic compare(input mov_rec_t e);
    check(out_illegal == e.illegal, "R8", "illegal", 32'(out_illegal), 32'(e.illegal));
    check(out_imm_form == e.imm_form, "R7", "form", 32'(out_imm_form), 32'(e.imm_form));
    check(out_dir == e.dir && out_wide == e.wide, "R2", "dir/wide",
          32'({out_dir, out_wide}), 32'({e.dir, e.wide}));
    check(out_mod == e.mod && out_reg == e.reg_f && out_rm == e.rm, "R3", "mod/reg/rm",
          32'({out_mod, out_reg, out_rm}), 32'({e.mod, e.reg_f, e.rm}));
    check(out_len == e.len, (e.mod == 2'b00 && e.rm == 3'b110 && !e.imm_form) ? "R5" : "R4",
          "len", 32'(out_len), 32'(e.len));
    check(out_disp == e.disp, "R6", "disp", 32'(out_disp), 32'(e.disp));
    check(out_imm == e.imm, "R7", "imm", 32'(out_imm), 32'(e.imm));
  endtask

  function automatic logic [52:0] snap();
    return {out_illegal, out_imm_form, out_dir, out_wide, out_mod, out_reg, out_rm,
            out_disp, out_imm, out_len, out_valid};
  endfunction

  initial begin
    int bi;
    bit acc_in, acc_out, pend_final, stalled;
    logic [52:0] stall_snap;
    bit timed_out;
    logic [7:0] b;

    void'($urandom(32'd20240611));

    // Directed corner cases
    add_imm(1'b0, 3'd0, 16'h0015);              // load 15h into AL
    add_rm(1'b1, 1'b1, 2'b00, 3'd0, 3'd4, 16'h0);  // no displacement
    add_rm(1'b1, 1'b1, 2'b00, 3'd0, 3'd6, 16'h1234); // direct address R5
    add_rm(1'b0, 1'b0, 2'b01, 3'd0, 3'd4, 16'h00A5); // disp8
    add_rm(1'b0, 1'b0, 2'b10, 3'd0, 3'd7, 16'h1234); // disp16
    add_rm(1'b1, 1'b1, 2'b11, 3'd0, 3'd3, 16'h0);  // register mode
    add_bad(8'hC3);
    add_rm(1'b0, 1'b1, 2'b11, 3'd3, 3'd0, 16'h0);  // resync after illegal
    add_bad(8'hFF);
    add_bad(8'h00);
    add_imm(1'b1, 3'd0, 16'hBEEF);
    add_rm(1'b1, 1'b0, 2'b01, 3'd5, 3'd6, 16'h0080); // mod01 r/m110 is disp8

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int c;
      c = int'($urandom % 10);
      if (c < 6) begin
        logic [1:0] md;
        logic [2:0] rmv;
        md = 2'($urandom);
        rmv = 3'($urandom);
        if (c == 0) begin md = 2'b00; rmv = 3'b110; end
        add_rm(1'($urandom), 1'($urandom), md, 3'($urandom), rmv, 16'($urandom));
      end else if (c < 9) begin
        add_imm(1'($urandom), 3'($urandom), 16'($urandom));
      end else begin
        b = 8'($urandom);
        while (b[7:2] == 6'b100010 || b[7:4] == 4'hB) b = 8'($urandom);
        add_bad(b);
      end
    end

    // Reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);

    bi = 0; acc_in = 0; acc_out = 0; pend_final = 0; stalled = 0; timed_out = 0;
    stall_snap = '0;
    for (int cyc = 0; ; cyc++) begin
      @(negedge clk);
      if (pend_final)
        check(out_valid == 1'b1, "R10", "record valid after last byte", 32'(out_valid), 32'd1);
      if (stalled)
        check(snap() == stall_snap, "R9", "record held under stall",
              32'(snap()), 32'(stall_snap));
      if (q_exp.size() == 0 && bi >= q_bytes.size() && !out_valid) break;
      if (cyc > 150000) begin
        timed_out = 1'b1;
        break;
      end
      out_ready = ($urandom % 4) != 0;
      in_valid  = (bi < q_bytes.size()) && (($urandom % 5) != 0);
      in_byte   = (bi < q_bytes.size()) ? q_bytes[bi] : 8'h00;
      #1;
      acc_out = out_valid && out_ready;
      acc_in  = in_valid && in_ready;
      stalled = out_valid && !out_ready;
      stall_snap = snap();
      if (stalled)
        check(in_ready == 1'b0, "R9", "in_ready low while stalled", 32'(in_ready), 32'd0);
      if (acc_out) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R10", "unexpected record", 32'd1, 32'd0);
        end else begin
          compare(q_exp[0]);
          void'(q_exp.pop_front());
        end
      end
      pend_final = 1'b0;
      if (acc_in) begin
        pend_final = q_last[bi];
        bi++;
      end
    end
    if (timed_out) check(1'b0, "R10", "watchdog expired", 32'(q_exp.size()), 32'd0);
    check(q_exp.size() == 0, "R10", "records left over", 32'(q_exp.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule